// File: doc/BRIEF.md
# Supply Window Monitor

This block decides whether an input supply is fit to feed a load. It takes two comparator results: one says the supply is below the lower bound, the other says it is above the upper bound. It also takes a lockout flag from the internal regulator. From these it produces a supply-good indication and a permit that enables the external pass transistor. All delays are counted in ticks of a slow timebase strobe (`tick`). The defaults assume a 5 µs tick.

The two fault directions are filtered differently. A low-side excursion must persist for a long window before it counts. A high-side excursion needs only a short window. A return into the window is accepted on the next clock edge with no filtering. After reset, or after lockout ends, the supply must stay in the window without a break for a long qualification period before anything is enabled. While a comparator is tripped, the block drives a hysteresis-current enable for that pin: a sink for the low-side pin and a source for the high-side pin. The analog side uses these to move the effective threshold.

Top module: `supply_window_monitor`

## Requirements
- R1: A low-side fault is recognised only after `uv_trip` is seen high on `UV_FILT_TICKS` consecutive tick edges. A shorter excursion leaves `gate_permit` at 1.
- R2: A high-side fault is recognised only after `ov_trip` is seen high on `OV_FILT_TICKS` consecutive tick edges. A shorter excursion leaves `gate_permit` at 1.
- R3: When a tripped comparator returns low, its fault clears on the next clock edge, whether or not a tick occurs.
- R4: If a comparator returns low before its filter expires, that filter count restarts from zero. A later excursion needs the full tick count again.
- R5: After reset or lockout, `supply_good` and `gate_permit` stay 0 until both comparators have been low for `POR_TICKS` consecutive tick edges. Any out-of-window cycle restarts this count. Once qualification is done, it is not repeated until the next reset or lockout.
- R6: `gate_permit` falls one clock after a fault is recognised. It returns to 1 one clock after the fault clears, provided qualification is done.
- R7: `supply_good` is 1 one clock after a cycle in which qualification is done, both comparators are low and lockout is 0. It uses no filter.
- R8: `uv_sink_en` and `ov_source_en` equal `uv_trip` and `ov_trip` delayed by one clock. They are 0 while lockout is active.
- R9: While `lockout` is 1, every output is 0 and all counters and the qualification state are cleared.
- R10: Filter and qualification counts advance only on cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe of the slow timebase |
| lockout | input | 1 | Regulator lockout; holds the block in reset while 1 |
| uv_trip | input | 1 | Low-side comparator, 1 = below the window |
| ov_trip | input | 1 | High-side comparator, 1 = above the window |
| supply_good | output | 1 | Qualified and currently inside the window |
| gate_permit | output | 1 | Pass transistor may be enabled |
| uv_sink_en | output | 1 | Enables the low-side pin hysteresis sink |
| ov_source_en | output | 1 | Enables the high-side pin hysteresis source |

## Verification
A filter counter that is off by one shows up as `gate_permit` falling one tick too early or too late. Directed checks sample one tick before and one tick after the expected recognition edge to catch this. A counter that fails to restart is exposed by a second excursion that gets a full-length filter window. A stale qualification flag shows as `supply_good` rising within a clock of lockout ending instead of `POR_TICKS` ticks later. A filter that keeps its fault after recovery is caught by checking `gate_permit` two clocks after recovery, with the tick strobe stopped.

// File: rtl/swm_pkg.sv
package swm_pkg;

    // Phase of the power-on qualification sequencer
    typedef enum logic {
        POR_WAIT  = 1'b0,
        POR_READY = 1'b1
    } por_phase_e;

    // Registered top-level outputs
    typedef struct packed {
        logic supply_good;
        logic gate_permit;
    } mon_out_t;

    // Counter width able to hold values 0..n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/swm_fault_filter.sv
module swm_fault_filter #(
    parameter int FILT_TICKS = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic trip,
    output logic fault_o,
    output logic hyst_o
);
    localparam int CW = swm_pkg::cnt_width(FILT_TICKS);
    localparam logic [CW-1:0] LAST = CW'(FILT_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fault;
        logic          hyst;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            st_d.hyst = trip;
            if (!trip) begin
                // recovery is accepted at once; count starts over
                st_d.cnt   = '0;
                st_d.fault = 1'b0;
            end else if (!st_q.fault && tick) begin
                if (st_q.cnt == LAST) begin
                    st_d.fault = 1'b1;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_o = st_q.fault;
    assign hyst_o  = st_q.hyst;

    assert_recover_at_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !trip |=> !fault_o);
    assert_fault_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(trip && tick && !clear));
    assert_hyst_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && !clear) |=> hyst_o);
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!fault_o && !hyst_o));

endmodule

// File: rtl/swm_por_qualifier.sv
module swm_por_qualifier #(
    parameter int POR_TICKS = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic in_window,
    output logic done_o
);
    import swm_pkg::*;

    localparam int CW = cnt_width(POR_TICKS);
    localparam logic [CW-1:0] LAST = CW'(POR_TICKS - 1);

    typedef struct packed {
        por_phase_e    phase;
        logic [CW-1:0] cnt;
    } por_state_t;

    por_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.phase = POR_WAIT;
            st_d.cnt   = '0;
        end else if (st_q.phase == POR_WAIT) begin
            if (!in_window) begin
                st_d.cnt = '0;
            end else if (tick) begin
                if (st_q.cnt == LAST) begin
                    st_d.phase = POR_READY;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= POR_WAIT;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = (st_q.phase == POR_READY);

    assert_qualify_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(tick && in_window && !clear));
    assert_qualify_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear) |=> done_o);

endmodule

// File: rtl/supply_window_monitor.sv
module supply_window_monitor #(
    parameter int UV_FILT_TICKS = 120,
    parameter int OV_FILT_TICKS = 1,
    parameter int POR_TICKS     = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lockout,
    input  logic uv_trip,
    input  logic ov_trip,
    output logic supply_good,
    output logic gate_permit,
    output logic uv_sink_en,
    output logic ov_source_en
);
    import swm_pkg::*;

    logic uv_fault, ov_fault, por_done;
    mon_out_t out_d, out_q;

    swm_fault_filter #(.FILT_TICKS(UV_FILT_TICKS)) u_uv_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (lockout),
        .tick    (tick),
        .trip    (uv_trip),
        .fault_o (uv_fault),
        .hyst_o  (uv_sink_en)
    );

    swm_fault_filter #(.FILT_TICKS(OV_FILT_TICKS)) u_ov_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (lockout),
        .tick    (tick),
        .trip    (ov_trip),
        .fault_o (ov_fault),
        .hyst_o  (ov_source_en)
    );

    swm_por_qualifier #(.POR_TICKS(POR_TICKS)) u_por (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (lockout),
        .tick      (tick),
        .in_window (!uv_trip && !ov_trip),
        .done_o    (por_done)
    );

    always_comb begin
        out_d.supply_good = !lockout && por_done && !uv_trip && !ov_trip;
        out_d.gate_permit = !lockout && por_done && !uv_fault && !ov_fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign supply_good = out_q.supply_good;
    assign gate_permit = out_q.gate_permit;

    assert_permit_drop_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_permit) |-> $past(uv_fault || ov_fault || lockout));
    assert_good_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        supply_good |-> $past(!uv_trip && !ov_trip && !lockout));
    assert_good_after_por_R5: assert property (@(posedge clk) disable iff (!rst_n)
        supply_good |-> por_done);
    assert_lockout_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> (!supply_good && !gate_permit && !uv_sink_en && !ov_source_en));

endmodule

// File: tb/supply_window_monitor_bench.sv
`timescale 1ns/1ps
module supply_window_monitor_bench;
    localparam int UVT = 6;
    localparam int OVT = 2;
    localparam int PORT = 20;
    localparam int TICK_DIV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic tick_en = 1'b1;
    logic lockout = 1'b0;
    logic uv_trip = 1'b1;
    logic ov_trip = 1'b0;
    logic supply_good, gate_permit, uv_sink_en, ov_source_en;
    int   tdiv = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick <= tick_en && (tdiv == TICK_DIV - 1);
    end

    supply_window_monitor #(
        .UV_FILT_TICKS(UVT), .OV_FILT_TICKS(OVT), .POR_TICKS(PORT)
    ) u_supply_window_monitor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lockout(lockout),
        .uv_trip(uv_trip), .ov_trip(ov_trip), .supply_good(supply_good),
        .gate_permit(gate_permit), .uv_sink_en(uv_sink_en), .ov_source_en(ov_source_en)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (tick !== 1'b1);
        end
        #1;
    endtask

    task automatic set_in(input logic uv, input logic ov);
        @(negedge clk);
        uv_trip = uv;
        ov_trip = ov;
    endtask

    task automatic t_reset_state();
        #1;
        check("R9", "supply_good in reset", supply_good, 0);
        check("R9", "gate_permit in reset", gate_permit, 0);
        cyc(3);
        @(negedge clk) rst_n = 1'b1;
        cyc(1);
        check("R5", "supply_good before qualify", supply_good, 0);
    endtask

    task automatic t_qualify();
        set_in(0, 0);
        wait_ticks(10);
        set_in(1, 0);
        cyc(2);
        set_in(0, 0);
        wait_ticks(PORT - 1);
        cyc(1);
        check("R5", "supply_good one tick short after restart", supply_good, 0);
        check("R5", "gate_permit one tick short", gate_permit, 0);
        wait_ticks(1);
        cyc(1);
        check("R5", "supply_good after full qualify", supply_good, 1);
        check("R6", "gate_permit after full qualify", gate_permit, 1);
    endtask

    task automatic t_uv_filter();
        set_in(1, 0);
        wait_ticks(UVT - 1);
        cyc(1);
        check("R1", "gate_permit kept on short dip", gate_permit, 1);
        check("R7", "supply_good drops unfiltered", supply_good, 0);
        check("R8", "uv_sink_en while tripped", uv_sink_en, 1);
        set_in(0, 0);
        cyc(1);
        check("R8", "uv_sink_en after release", uv_sink_en, 0);
        check("R7", "supply_good back in window", supply_good, 1);
        set_in(1, 0);
        wait_ticks(UVT - 1);
        cyc(1);
        check("R4", "count restarted after dip", gate_permit, 1);
        wait_ticks(1);
        cyc(1);
        check("R1", "gate_permit after full UV window", gate_permit, 0);
        tick_en = 1'b0;
        set_in(0, 0);
        cyc(2);
        check("R3", "gate_permit restored without tick", gate_permit, 1);
        tick_en = 1'b1;
    endtask

    task automatic t_ov_filter();
        set_in(0, 1);
        wait_ticks(OVT - 1);
        cyc(1);
        check("R2", "gate_permit kept on short OV", gate_permit, 1);
        check("R8", "ov_source_en while tripped", ov_source_en, 1);
        wait_ticks(1);
        cyc(1);
        check("R2", "gate_permit after full OV window", gate_permit, 0);
        set_in(0, 0);
        cyc(2);
        check("R6", "gate_permit after OV recovery", gate_permit, 1);
        check("R8", "ov_source_en after recovery", ov_source_en, 0);
    endtask

    task automatic t_tick_gating();
        tick_en = 1'b0;
        set_in(1, 0);
        cyc(40);
        check("R10", "no fault without ticks", gate_permit, 1);
        set_in(0, 0);
        cyc(1);
        tick_en = 1'b1;
    endtask

    task automatic t_lockout();
        @(negedge clk);
        lockout = 1'b1;
        uv_trip = 1'b1;
        cyc(2);
        check("R9", "gate_permit under lockout", gate_permit, 0);
        check("R9", "uv_sink_en under lockout", uv_sink_en, 0);
        check("R9", "supply_good under lockout", supply_good, 0);
        @(negedge clk);
        uv_trip = 1'b0;
        lockout = 1'b0;
        cyc(2);
        check("R9", "qualification cleared by lockout", supply_good, 0);
        wait_ticks(PORT);
        cyc(1);
        check("R5", "supply_good after requalify", supply_good, 1);
        check("R6", "gate_permit after requalify", gate_permit, 1);
    endtask

    initial begin
        t_reset_state();
        t_qualify();
        t_uv_filter();
        t_ov_filter();
        t_tick_gating();
        t_lockout();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule